// File: doc/BRIEF.md
# Ping-Pong Register-Set Word DMA Channel

This block is a single-direction word DMA channel. It issues word transfer requests, each carrying a local-bus word address and a peripheral-bus word address, into a valid/ready transaction queue. Software programs two alternating register sets over a small configuration port. Each set holds a local start address, a peripheral start address and a length/control word. While one set runs, software may load the other. When the running set's count reaches zero, the hardware clears that set's arm bit and pulses `done`. It then continues straight into the other set if that set is armed; otherwise it goes idle.

The channel treats owning the queue as a shared resource. A direct slave access aimed at the peripheral bus that arrives while the channel owns the queue is answered with retry and remembered as pending. At the next word boundary the channel releases the queue. It stays off the queue for as long as the slave request is held, and for at least one cycle. It then resumes from the saved addresses and count, which are held live in the register set.

Top module: `pingpong_dma_chan`

## Requirements
- R1: Both start-address registers are word addresses. Their two least significant bits always read back as zero, whatever was written.
- R2: An armed set issues exactly as many words as its count field holds. The first word carries the programmed start addresses, and both addresses advance by 4 after each accepted word. The advanced addresses read back from the set.
- R3: When a set's count reaches zero, bit 31 of its length register clears by itself, the count reads 0, and `done` is high for exactly one cycle for that set.
- R4: A set armed with a count of zero completes without issuing any word, clears its bit 31 and pulses `done` once.
- R5: When a set completes and the other set is armed, the channel moves on to the other set without dropping `busy`, and `act_set` shows the new index. When the other set is not armed, `busy` falls.
- R6: Configuration writes are accepted while a transfer runs. An idle set programmed and armed during a transfer takes effect.
- R7: While `q_valid` is high and `q_ready` is low, the request holds its addresses and the live count does not change. The live count is readable in bits 15:0 of the active set's length register.
- R8: A `slv_req` seen while the channel owns the queue gets `slv_retry` high. The channel then drops `q_valid` and `slv_retry` at the next word boundary and stays off the queue while `slv_req` is held, for at least one cycle. It then resumes with no lost or repeated word.
- R9: Register map: `cfg_addr[2]` selects the set, and `cfg_addr[1:0]` selects the register (0 = local address, 1 = peripheral address, 2 = length, 3 = reads zero). In the length register, bit 31 is the arm bit, bits 15:0 are the count, and all other bits read zero. A write to the length register with bit 31 low does not start a transfer. `cfg_rdata` shows the register addressed in the previous cycle.
- R10: After reset the channel is idle, `q_valid` and `done` are low, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register select: {set, register} |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered read data |
| q_valid | output | 1 | Word request presented to the queue |
| q_ready | input | 1 | Queue accepts the presented word |
| q_laddr | output | 32 | Local-bus word address of the request |
| q_paddr | output | 32 | Peripheral-bus word address of the request |
| slv_req | input | 1 | Direct slave access wants the queue |
| slv_retry | output | 1 | Slave access told to retry |
| busy | output | 1 | Channel is running a set |
| act_set | output | 1 | Index of the active set |
| done | output | 1 | One-cycle pulse when a set completes |

## Verification
The bench goes after the hand-over between sets. A design that idled between armed sets, or that replayed or skipped the first word of the second set, would show up as a `busy` fall or a broken address sequence. Back-pressure cases check that a stalled request neither advances its addresses nor loses count, and that the live count read mid-transfer matches the words already accepted. The yield case holds a slave request across a transfer. A channel that never released the queue would keep `slv_retry` high forever, and one that resumed wrongly would repeat or drop a word. Zero-count arming and reserved-bit readback catch designs that hang on an empty set or keep junk bits in the length register.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;
  localparam logic [1:0] REG_LADDR = 2'd0;
  localparam logic [1:0] REG_PADDR = 2'd1;
  localparam logic [1:0] REG_LEN   = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_YIELD = 2'd2
  } eng_st_t;
endpackage

// File: rtl/ppdma_regfile.sv
module ppdma_regfile
  import ppdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [2:0]             addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  input  logic                   adv,
  input  logic                   clr,
  input  logic                   eng_set,
  output logic [1:0][AW-1:0]     laddr_o,
  output logic [1:0][AW-1:0]     paddr_o,
  output logic [1:0][CW-1:0]     cnt_o,
  output logic [1:0]             en_o
);
  localparam int EN_BIT = DW - 1;
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

  for (genvar g = 0; g < 2; g++) begin : g_set
    logic [AW-1:0] la, pa;
    logic [CW-1:0] cnt;
    logic          en;
    logic          hit, mine;

    assign hit  = wr_en && (addr[2] == 1'(g));
    assign mine = (eng_set == 1'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        la  <= '0;
        pa  <= '0;
        cnt <= '0;
        en  <= 1'b0;
      end else begin
        if (hit && addr[1:0] == REG_LADDR) la <= wdata[AW-1:0] & ALIGN_MASK;
        else if (adv && mine)              la <= la + STEP;

        if (hit && addr[1:0] == REG_PADDR) pa <= wdata[AW-1:0] & ALIGN_MASK;
        else if (adv && mine)              pa <= pa + STEP;

        if (hit && addr[1:0] == REG_LEN) begin
          cnt <= wdata[CW-1:0];
          en  <= wdata[EN_BIT];
        end else begin
          if (adv && mine) cnt <= cnt - 1'b1;
          if (clr && mine) en  <= 1'b0;
        end
      end
    end

    assign laddr_o[g] = la;
    assign paddr_o[g] = pa;
    assign cnt_o[g]   = cnt;
    assign en_o[g]    = en;
  end

  logic [DW-1:0] rd_n;
  always_comb begin
    rd_n = '0;
    case (addr[1:0])
      REG_LADDR: rd_n = DW'(laddr_o[addr[2]]);
      REG_PADDR: rd_n = DW'(paddr_o[addr[2]]);
      REG_LEN: begin
        rd_n[CW-1:0] = cnt_o[addr[2]];
        rd_n[EN_BIT] = en_o[addr[2]];
      end
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr_en) |=> laddr_o[$past(eng_set)] == $past(laddr_o[eng_set]) + STEP);

  // R3
  arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !wr_en) |=> !en_o[$past(eng_set)]);
endmodule

// File: rtl/ppdma_engine.sv
module ppdma_engine
  import ppdma_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] en_i,
  input  logic [1:0] cnt_zero_i,
  input  logic       q_ready,
  input  logic       slv_req,
  output logic       q_valid,
  output logic       slv_retry,
  output logic       adv,
  output logic       clr,
  output logic       act,
  output logic       busy,
  output logic       done
);
  eng_st_t st;
  logic    pend, own, cur_zero, accept, pend_n;

  assign own       = (st == ST_RUN);
  assign cur_zero  = cnt_zero_i[act];
  assign q_valid   = own && !cur_zero;
  assign accept    = q_valid && q_ready;
  assign slv_retry = slv_req && own;
  assign pend_n    = pend || slv_retry;
  assign adv       = accept;
  assign clr       = own && cur_zero;
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      act  <= 1'b0;
      pend <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= clr;
      if (st != ST_RUN)  pend <= 1'b0;
      else if (slv_retry) pend <= 1'b1;

      case (st)
        ST_IDLE: begin
          if (en_i[0]) begin
            act <= 1'b0;
            st  <= ST_RUN;
          end else if (en_i[1]) begin
            act <= 1'b1;
            st  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (clr) begin
            if (en_i[!act]) begin
              act <= !act;
              st  <= pend_n ? ST_YIELD : ST_RUN;
            end else begin
              st <= ST_IDLE;
            end
          end else if (accept && pend_n) begin
            st <= ST_YIELD;
          end
        end
        ST_YIELD: if (!slv_req) st <= ST_RUN;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  pend_yields_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && pend) |=> !q_valid && !slv_retry);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !en_i[!act]) |=> !busy);
endmodule

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan
  import ppdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          q_valid,
  input  logic          q_ready,
  output logic [AW-1:0] q_laddr,
  output logic [AW-1:0] q_paddr,
  input  logic          slv_req,
  output logic          slv_retry,
  output logic          busy,
  output logic          act_set,
  output logic          done
);
  logic [1:0][AW-1:0] laddr, paddr;
  logic [1:0][CW-1:0] cnt;
  logic [1:0]         en, cnt_zero;
  logic               adv, clr, act;

  for (genvar g = 0; g < 2; g++) begin : g_zero
    assign cnt_zero[g] = (cnt[g] == '0);
  end

  ppdma_regfile #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .adv(adv), .clr(clr), .eng_set(act),
    .laddr_o(laddr), .paddr_o(paddr), .cnt_o(cnt), .en_o(en)
  );

  ppdma_engine #(.CW(CW)) u_eng (
    .clk(clk), .rst(rst), .en_i(en), .cnt_zero_i(cnt_zero), .q_ready(q_ready),
    .slv_req(slv_req), .q_valid(q_valid), .slv_retry(slv_retry), .adv(adv),
    .clr(clr), .act(act), .busy(busy), .done(done)
  );

  assign act_set = act;
  assign q_laddr = laddr[act];
  assign q_paddr = paddr[act];

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !q_ready && !cfg_we) |=> q_valid && $stable(q_laddr) && $stable(q_paddr));
endmodule

// File: tb/tb_pingpong_dma_chan.sv
`timescale 1ns/1ps
module tb_pingpong_dma_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        q_valid, q_ready = 1'b0;
  logic [31:0] q_laddr, q_paddr;
  logic        slv_req = 1'b0;
  logic        slv_retry, busy, act_set, done;

  int total = 0;
  int bad = 0;

  logic [31:0] mon_l [0:63];
  logic [31:0] mon_p [0:63];
  int mon_n = 0, done_n = 0, bfall_n = 0;
  logic busy_prev = 1'b0, saw_act1 = 1'b0;

  always #5 clk = ~clk;

  pingpong_dma_chan dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .q_valid(q_valid), .q_ready(q_ready), .q_laddr(q_laddr),
    .q_paddr(q_paddr), .slv_req(slv_req), .slv_retry(slv_retry), .busy(busy),
    .act_set(act_set), .done(done)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (q_valid && q_ready && mon_n < 64) begin
        mon_l[mon_n] = q_laddr;
        mon_p[mon_n] = q_paddr;
        mon_n++;
      end
      if (done) done_n++;
      if (busy_prev && !busy) bfall_n++;
      if (busy && act_set) saw_act1 = 1'b1;
      busy_prev = busy;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    mon_n = 0; done_n = 0; bfall_n = 0; saw_act1 = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    @(posedge clk); #1;
    d = cfg_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      if (!busy) break;
    end
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic check_seq(input int first, input int n, input logic [31:0] l0,
                           input logic [31:0] p0, input string tag);
    for (int i = 0; i < n; i++) begin
      check(mon_l[first+i] == l0 + 32'(4*i), tag, mon_l[first+i], l0 + 32'(4*i));
      check(mon_p[first+i] == p0 + 32'(4*i), tag, mon_p[first+i], p0 + 32'(4*i));
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(busy == 1'b0, "R10 busy after reset", 32'(busy), 0);
    check(q_valid == 1'b0, "R10 q_valid after reset", 32'(q_valid), 0);
    check(done == 1'b0, "R10 done after reset", 32'(done), 0);
    rd(3'b010, d); check(d == 0, "R10 set0 length", d, 0);
    rd(3'b100, d); check(d == 0, "R10 set1 local addr", d, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(3'b110, 32'h7FFF_1234);
    rd(3'b110, d); check(d == 32'h0000_1234, "R9 length reserved bits", d, 32'h0000_1234);
    rd(3'b111, d); check(d == 0, "R9 index 3 reads zero", d, 0);
    check(busy == 1'b0, "R9 unarmed write starts nothing", 32'(busy), 0);
    wr(3'b110, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    mon_clear();
    q_ready = 1'b1;
    wr(3'b000, 32'h0000_0103);
    wr(3'b001, 32'h4000_0001);
    rd(3'b000, d); check(d == 32'h100, "R1 local addr aligned", d, 32'h100);
    rd(3'b001, d); check(d == 32'h4000_0000, "R1 periph addr aligned", d, 32'h4000_0000);
    wr(3'b010, 32'h8000_0003);
    wait_idle();
    check(mon_n == 3, "R2 word count", 32'(mon_n), 3);
    check_seq(0, 3, 32'h100, 32'h4000_0000, "R2 address sequence");
    check(done_n == 1, "R3 one-cycle done", 32'(done_n), 1);
    rd(3'b010, d); check(d == 0, "R3 arm bit and count cleared", d, 0);
    rd(3'b000, d); check(d == 32'h10C, "R2 advanced addr readback", d, 32'h10C);
  endtask

  task automatic t_zero();
    logic [31:0] d;
    mon_clear();
    q_ready = 1'b1;
    wr(3'b110, 32'h8000_0000);
    wait_idle();
    check(mon_n == 0, "R4 no words for zero count", 32'(mon_n), 0);
    check(done_n == 1, "R4 done pulse", 32'(done_n), 1);
    rd(3'b110, d); check(d == 0, "R4 arm bit cleared", d, 0);
  endtask

  task automatic t_pingpong();
    logic [31:0] d;
    mon_clear();
    q_ready = 1'b0;
    wr(3'b000, 32'h400);
    wr(3'b001, 32'h9000);
    wr(3'b010, 32'h8000_0002);
    repeat (3) @(posedge clk);
    #1;
    check(busy && !act_set, "R6 running on set 0", {30'b0, busy, act_set}, 32'h2);
    wr(3'b100, 32'h500);
    wr(3'b101, 32'hA000);
    wr(3'b110, 32'h8000_0003);
    q_ready = 1'b1;
    wait_idle();
    check(mon_n == 5, "R5 words across both sets", 32'(mon_n), 5);
    check_seq(0, 2, 32'h400, 32'h9000, "R5 set0 sequence");
    check_seq(2, 3, 32'h500, 32'hA000, "R6 set1 sequence");
    check(done_n == 2, "R5 two done pulses", 32'(done_n), 2);
    check(bfall_n == 1, "R5 busy held across switch", 32'(bfall_n), 1);
    check(saw_act1 == 1'b1, "R5 act_set shows set 1", 32'(saw_act1), 1);
    rd(3'b110, d); check(d == 0, "R5 set1 arm cleared", d, 0);
  endtask

  task automatic t_stall();
    logic [31:0] d;
    mon_clear();
    q_ready = 1'b0;
    wr(3'b000, 32'h600);
    wr(3'b001, 32'hB000);
    wr(3'b010, 32'h8000_0004);
    repeat (5) @(posedge clk);
    #1;
    check(mon_n == 0, "R7 nothing accepted while stalled", 32'(mon_n), 0);
    check(q_valid == 1'b1, "R7 valid held", 32'(q_valid), 1);
    check(q_laddr == 32'h600, "R7 local addr held", q_laddr, 32'h600);
    check(q_paddr == 32'hB000, "R7 periph addr held", q_paddr, 32'hB000);
    rd(3'b010, d); check(d == 32'h8000_0004, "R7 live count before", d, 32'h8000_0004);
    q_ready = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    q_ready = 1'b0;
    check(mon_n == 2, "R7 two accepted", 32'(mon_n), 2);
    check(q_laddr == 32'h608, "R7 addr after two words", q_laddr, 32'h608);
    rd(3'b010, d); check(d == 32'h8000_0002, "R7 live count mid", d, 32'h8000_0002);
    q_ready = 1'b1;
    wait_idle();
    check(mon_n == 4, "R7 all words after release", 32'(mon_n), 4);
    check_seq(0, 4, 32'h600, 32'hB000, "R7 sequence");
  endtask

  task automatic t_yield();
    bit seen_retry = 1'b0;
    bit granted = 1'b0;
    mon_clear();
    q_ready = 1'b1;
    wr(3'b000, 32'h700);
    wr(3'b001, 32'hC000);
    wr(3'b010, 32'h8000_0006);
    repeat (2) @(posedge clk);
    #1;
    slv_req = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (slv_retry) seen_retry = 1'b1;
      else begin
        granted = 1'b1;
        check(q_valid == 1'b0, "R8 queue released", 32'(q_valid), 0);
        check(busy == 1'b1, "R8 still busy during yield", 32'(busy), 1);
        break;
      end
    end
    @(posedge clk); #1;
    slv_req = 1'b0;
    check(seen_retry, "R8 retry while owned", 32'(seen_retry), 1);
    check(granted, "R8 slave access let through", 32'(granted), 1);
    wait_idle();
    check(mon_n == 6, "R8 no lost or extra word", 32'(mon_n), 6);
    check_seq(0, 6, 32'h700, 32'hC000, "R8 resume sequence");
    check(done_n == 1, "R8 completion after yield", 32'(done_n), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_regmap();
    t_single();
    t_zero();
    t_pingpong();
    t_stall();
    t_yield();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule